// File: doc/BRIEF.md
# Real-Time Clock Interrupt Status and Control Register File

This block holds the interrupt side of a real-time clock: the three event flags (periodic, alarm, update-ended), the combined request flag, and the enable register that gates them onto a level interrupt line. It sits behind a two-address byte port. A write to the even address picks a register index, and the odd address reads or writes the selected byte. Timekeeping and event generation live elsewhere. This block only receives one-cycle event pulses and turns them into flags and a request.

Software services the interrupt by reading the status register. That single read returns the flags and clears all of them. Enabling a source whose flag is already pending raises the line at once, so an event that arrived while its source was disabled is not lost. Indexes other than the four control registers hold plain byte storage.

Top module: `rtc_irq_status`

## Requirements
- R1: A synchronous active-low reset sets the following state. The control byte at index 0x0A reads 0x26. The enable byte at index 0x0B reads 0x02, with its bits 6, 5 and 3 cleared. The status byte at index 0x0C reads 0x00. The byte at index 0x0D reads 0x80. The interrupt line is low.
- R2: Port behaviour depends on the address.
  - A write with `bus_addr`=0 loads the low 7 bits of the data as the index, and bit 7 is dropped.
  - A read with `bus_addr`=0 returns 0xFF.
  - With `bus_addr`=1, the port reads or writes the byte at the current index.
- R3: A read of the status byte (index 0x0C) with no event in the same cycle leaves it at 0x00 and the line low on the next cycle.
- R4: A read of the status byte returns its value from before the clear. The status byte is laid out as follows:
  - bit 7: combined request
  - bit 6: periodic flag
  - bit 5: alarm flag
  - bit 4: update-ended flag
- R5: Writes to index 0x0C and index 0x0D change nothing, and index 0x0D always reads 0x80.
- R6: On a write to the enable byte, the combined request and the line are recomputed at once. They go high if any enable bit 6, 5 or 4 matches a set flag. Otherwise they go low, and the flags themselves are kept.
- R7: An event pulse always sets its flag. It sets the combined request and raises the line only if its enable bit, which sits at the same position as the flag, is 1.
- R8: An event whose flag is already set changes neither the status byte nor the line.
- R9: Writing the enable byte with bit 7 (hold) set stores bit 4 (update-ended enable) as 0, and the new request is computed with that bit at 0.
- R10: Bits 3..0 of the status byte always read as zero.
- R11: An event arriving in the same cycle as a clearing read of the status byte survives. Its flag is set afterwards, and it raises the request if enabled.
- R12: Bit 7 of the control byte at index 0x0A is read-only, and writes change only bits 6..0.
- R13: Any index other than 0x0A..0x0D stores the last byte written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Byte write strobe |
| bus_re | input | 1 | Byte read strobe (a read of index 0x0C clears it) |
| bus_addr | input | 1 | 0 selects the index, 1 selects the data byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address and index |
| evt_periodic | input | 1 | One-cycle periodic event pulse |
| evt_alarm | input | 1 | One-cycle alarm match pulse |
| evt_update | input | 1 | One-cycle update-ended pulse |
| status_byte | output | 8 | Live copy of the status byte |
| irq_line | output | 1 | Level interrupt request |

## Verification
The bench targets several corner cases, each of which catches a specific class of bug:
- **Pending flag, then enable.** A flag is raised while its source is disabled, and the source is enabled afterwards. A design that only looks at fresh events would leave the line low here.
- **Enable write that clears nothing.** An enable write matches no pending flag. A design that keeps the old request would hold the line high.
- **Event during a clearing read.** An event lands in the cycle of a clearing read. A design that applies the clear last would lose that event.
- **Hold bit with update-ended enable.** The hold bit is written together with the update-ended enable while that flag is pending. A design that computes the request from the raw written byte would raise a spurious interrupt.
- **Read-only locations.** Writes to the status and fixed byte must change nothing. The read-only bit of the control byte must keep its value.

// File: rtl/rtcs_pkg.sv
// Shared constants for the clock interrupt register file: register
// indexes and bit positions that software decodes.
package rtcs_pkg;
    localparam int BYTE_W  = 8;
    localparam int IDX_CTL = 10;   // control byte, bit 7 read-only
    localparam int IDX_ENA = 11;   // enable byte
    localparam int IDX_STS = 12;   // status byte, clear on read
    localparam int IDX_FIX = 13;   // fixed read-only byte

    localparam int CTL_RO  = 7;    // read-only bit of control byte
    localparam int ENA_HLD = 7;    // hold bit of enable byte
    localparam int ENA_PER = 6;
    localparam int ENA_ALM = 5;
    localparam int ENA_UPD = 4;
    localparam int ENA_SQW = 3;

    localparam int STS_REQ = 7;    // combined request bit
    localparam int SRC_N   = 3;    // number of event sources
    localparam int SRC_LSB = 4;    // status bit of the lowest source

    // Enable bits cleared by reset on top of the reset value.
    localparam logic [BYTE_W-1:0] ENA_RST_CLR =
        (8'd1 << ENA_PER) | (8'd1 << ENA_ALM) | (8'd1 << ENA_SQW);
endpackage

// File: rtl/rtcs_port_decode.sv
// Index register and strobe decode for the two-address byte port.
// Assumes at most one of write/read strobes is acted on per address per cycle.
module rtcs_port_decode #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic             bus_re,
    input  logic             bus_addr,
    input  logic [IDX_W-1:0] idx_wdata,
    output logic [IDX_W-1:0] cur_idx,
    output logic             data_wr,
    output logic             data_rd
);
    // Data-side strobes for the selected byte.
    always_comb begin
        data_wr = bus_we & bus_addr;
        data_rd = bus_re & bus_addr;
    end

    // Index load from the even address, upper bits of the byte dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_idx <= '0;
        else if (bus_we && !bus_addr)
            cur_idx <= idx_wdata;
    end
endmodule

// File: rtl/rtcs_ctrl_regs.sv
// Control and enable bytes. The enable byte drops the update-ended
// enable whenever the hold bit is written as 1.
module rtcs_ctrl_regs
    import rtcs_pkg::*;
#(
    parameter logic [7:0] CTL_INIT = 8'h26,
    parameter logic [7:0] ENA_INIT = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_ena,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] ctl_q,
    output logic [BYTE_W-1:0] ena_q,
    output logic [BYTE_W-1:0] ena_wval
);
    // Value the enable byte takes on a write, hold bit applied.
    always_comb begin
        ena_wval = wdata;
        if (wdata[ENA_HLD])
            ena_wval[ENA_UPD] = 1'b0;
    end

    // Control byte: keeps its read-only bit across writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= CTL_INIT;
        else if (wr_ctl)
            ctl_q <= {ctl_q[CTL_RO], wdata[CTL_RO-1:0]};
    end

    // Enable byte: reset value with source and square-wave enables off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ena_q <= ENA_INIT & ~ENA_RST_CLR;
        else if (wr_ena)
            ena_q <= ena_wval;
    end
endmodule

// File: rtl/rtcs_flag_unit.sv
// Event flags, combined request and interrupt line. A clearing read is
// applied before events of the same cycle, so those events survive.
// Assumes an enable write and a status read never share a cycle.
module rtcs_flag_unit
    import rtcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] evt,
    input  logic             clr_rd,
    input  logic             ena_wr,
    input  logic [SRC_N-1:0] en_new,
    input  logic [SRC_N-1:0] en_cur,
    output logic [SRC_N-1:0] flags_q,
    output logic             req_q,
    output logic             irq_q
);
    logic [SRC_N-1:0] kept;
    logic [SRC_N-1:0] fresh;
    logic [SRC_N-1:0] flags_d;
    logic             req_d;

    // Next flags and request from clear, events and enable writes.
    always_comb begin
        kept    = clr_rd ? '0 : flags_q;
        fresh   = evt & ~kept;
        flags_d = kept | evt;
        if (ena_wr)
            req_d = |((en_new & flags_q) | (fresh & en_new));
        else if (clr_rd)
            req_d = |(fresh & en_cur);
        else
            req_d = req_q | (|(fresh & en_cur));
    end

    // State update; the line is a separate flop fed by the same decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            req_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            flags_q <= flags_d;
            req_q   <= req_d;
            irq_q   <= req_d;
        end
    end
endmodule

// File: rtl/rtcs_byte_store.sv
// Plain byte storage for every index; no reset (contents undefined
// until written). The caller masks writes to control indexes.
module rtcs_byte_store
    import rtcs_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        // One storage byte per index.
        always_ff @(posedge clk) begin
            if (we && idx == IDX_W'(g))
                mem[g] <= wdata;
        end
    end

    // Asynchronous read of the selected byte.
    always_comb rdata = mem[idx];
endmodule

// File: rtl/rtc_irq_status.sv
// Top of the clock interrupt register file: byte port, control and
// enable bytes, clear-on-read status byte, interrupt line and byte store.
// Assumes event inputs are one-cycle pulses synchronous to clk.
module rtc_irq_status
    import rtcs_pkg::*;
#(
    parameter int         IDX_W    = 7,
    parameter logic [7:0] CTL_INIT = 8'h26,
    parameter logic [7:0] ENA_INIT = 8'h02,
    parameter logic [7:0] FIX_VAL  = 8'h80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic       bus_re,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       evt_periodic,
    input  logic       evt_alarm,
    input  logic       evt_update,
    output logic [7:0] status_byte,
    output logic       irq_line
);
    localparam logic [IDX_W-1:0] SEL_CTL = IDX_W'(IDX_CTL);
    localparam logic [IDX_W-1:0] SEL_ENA = IDX_W'(IDX_ENA);
    localparam logic [IDX_W-1:0] SEL_STS = IDX_W'(IDX_STS);
    localparam logic [IDX_W-1:0] SEL_FIX = IDX_W'(IDX_FIX);
    localparam int               SRC_MSB = SRC_LSB + SRC_N - 1;

    logic [IDX_W-1:0]  cur_idx;
    logic              data_wr, data_rd;
    logic              hit_ctl, hit_ena, hit_sts, hit_fix;
    logic [BYTE_W-1:0] ctl_q, ctrl_b, ena_wval, store_rdata;
    logic [SRC_N-1:0]  flags_q;
    logic              req_q;

    rtcs_port_decode #(.IDX_W(IDX_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .idx_wdata (bus_wdata[IDX_W-1:0]),
        .cur_idx   (cur_idx),
        .data_wr   (data_wr),
        .data_rd   (data_rd)
    );

    // Index match for the four control locations.
    always_comb begin
        hit_ctl = (cur_idx == SEL_CTL);
        hit_ena = (cur_idx == SEL_ENA);
        hit_sts = (cur_idx == SEL_STS);
        hit_fix = (cur_idx == SEL_FIX);
    end

    rtcs_ctrl_regs #(.CTL_INIT(CTL_INIT), .ENA_INIT(ENA_INIT)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctl   (data_wr & hit_ctl),
        .wr_ena   (data_wr & hit_ena),
        .wdata    (bus_wdata),
        .ctl_q    (ctl_q),
        .ena_q    (ctrl_b),
        .ena_wval (ena_wval)
    );

    rtcs_flag_unit u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     ({evt_periodic, evt_alarm, evt_update}),
        .clr_rd  (data_rd & hit_sts),
        .ena_wr  (data_wr & hit_ena),
        .en_new  (ena_wval[SRC_MSB:SRC_LSB]),
        .en_cur  (ctrl_b[SRC_MSB:SRC_LSB]),
        .flags_q (flags_q),
        .req_q   (req_q),
        .irq_q   (irq_line)
    );

    rtcs_byte_store #(.IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .we    (data_wr & ~(hit_ctl | hit_ena | hit_sts | hit_fix)),
        .idx   (cur_idx),
        .wdata (bus_wdata),
        .rdata (store_rdata)
    );

    // Status byte assembly: request, source flags, zero low nibble.
    always_comb status_byte = {req_q, flags_q, {SRC_LSB{1'b0}}};

    // Read data mux by address and index.
    always_comb begin
        if (!bus_addr)      bus_rdata = 8'hFF;
        else if (hit_ctl)   bus_rdata = ctl_q;
        else if (hit_ena)   bus_rdata = ctrl_b;
        else if (hit_sts)   bus_rdata = status_byte;
        else if (hit_fix)   bus_rdata = FIX_VAL;
        else                bus_rdata = store_rdata;
    end
endmodule

// File: rtl/rtc_irq_status_chk.sv
// Property checker for rtc_irq_status, attached by bind below.
module rtc_irq_status_chk #(
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic             bus_re,
    input logic             bus_addr,
    input logic [7:0]       bus_wdata,
    input logic [7:0]       bus_rdata,
    input logic             evt_periodic,
    input logic             evt_alarm,
    input logic             evt_update,
    input logic [7:0]       status_byte,
    input logic             irq_line,
    input logic [IDX_W-1:0] cur_idx,
    input logic [7:0]       ctrl_b
);
    logic [2:0] evt;
    logic       rd_c, wr_c, b_wr;
    logic [2:0] eff_en;

    always_comb begin
        evt    = {evt_periodic, evt_alarm, evt_update};
        rd_c   = bus_re & bus_addr & (cur_idx == IDX_W'(12));
        wr_c   = bus_we & bus_addr & ((cur_idx == IDX_W'(12)) | (cur_idx == IDX_W'(13)));
        b_wr   = bus_we & bus_addr & (cur_idx == IDX_W'(11));
        eff_en = {bus_wdata[6:5], bus_wdata[4] & ~bus_wdata[7]};
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (status_byte == 8'h00 && !irq_line && ctrl_b[6:5] == 2'b00 && !ctrl_b[3]));

    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && evt == 3'b000) |=> (status_byte == 8'h00 && !irq_line));

    a_r4_read_value: assert property (@(posedge clk) disable iff (!rst_n)
        rd_c |-> (bus_rdata == status_byte));

    a_r5_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c && !rd_c && evt == 3'b000) |=> ($stable(status_byte) && $stable(irq_line)));

    a_r6_pending_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && (eff_en & status_byte[6:4]) != 3'b000) |=> irq_line);

    a_r6_no_match_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && (eff_en & (status_byte[6:4] | evt)) == 3'b000) |=> !irq_line);

    a_r7_fresh_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_wr && (evt & ~status_byte[6:4] & ctrl_b[6:4]) != 3'b000) |=> (irq_line && status_byte[7]));

    a_r9_hold_drops_upd: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && bus_wdata[7]) |=> !ctrl_b[4]);

    a_r11_event_survives: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && evt != 3'b000) |=> (status_byte[6:4] == $past(evt)));
endmodule

bind rtc_irq_status rtc_irq_status_chk #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_re       (bus_re),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .evt_periodic (evt_periodic),
    .evt_alarm    (evt_alarm),
    .evt_update   (evt_update),
    .status_byte  (status_byte),
    .irq_line     (irq_line),
    .cur_idx      (cur_idx),
    .ctrl_b       (ctrl_b)
);

// File: tb/tb_rtc_irq_status.sv
module tb_rtc_irq_status;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] I_CTL = 8'h0A, I_ENA = 8'h0B, I_STS = 8'h0C, I_FIX = 8'h0D;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0, bus_re = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       evt_periodic = 1'b0, evt_alarm = 1'b0, evt_update = 1'b0;
    logic [7:0] status_byte;
    logic       irq_line;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_irq_status dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
        .status_byte(status_byte), .irq_line(irq_line)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 1'b0;
        #1;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] val);
        wr_byte(1'b0, idx);
        wr_byte(1'b1, val);
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] v);
        wr_byte(1'b0, idx);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0; bus_addr = 1'b0;
        #1;
    endtask

    task automatic pulse(input logic p, input logic a, input logic u);
        @(negedge clk);
        evt_periodic = p; evt_alarm = a; evt_update = u;
        @(negedge clk);
        evt_periodic = 1'b0; evt_alarm = 1'b0; evt_update = 1'b0;
        #1;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic t_reset_values();
        logic [7:0] v;
        chk("R1 status", status_byte, 8'h00);
        chk("R1 irq", {7'd0, irq_line}, 8'h00);
        reg_read(I_CTL, v); chk("R1 ctl", v, 8'h26);
        reg_read(I_ENA, v); chk("R1 ena", v, 8'h02);
        reg_read(I_FIX, v); chk("R1 fixed", v, 8'h80);
        reg_read(I_STS, v); chk("R1 sts", v, 8'h00);
    endtask

    task automatic t_index_port();
        logic [7:0] v;
        @(negedge clk);
        bus_re = 1'b1; bus_addr = 1'b0;
        #1 chk("R2 even read", bus_rdata, 8'hFF);
        @(negedge clk);
        bus_re = 1'b0;
        reg_write(8'h8E, 8'h5A);
        reg_write(8'h21, 8'hC3);
        reg_read(8'h0E, v); chk("R2 index bit7 dropped", v, 8'h5A);
        reg_read(8'h21, v); chk("R13 store", v, 8'hC3);
    endtask

    task automatic t_masked_event();
        logic [7:0] v;
        pulse(1'b1, 1'b0, 1'b0);
        chk("R7 disabled flag", status_byte, 8'h40);
        chk("R7 disabled irq", {7'd0, irq_line}, 8'h00);
        chk("R10 low nibble", {4'd0, status_byte[3:0]}, 8'h00);
        reg_read(I_STS, v);
        chk("R4 read value", v, 8'h40);
        chk("R3 cleared", status_byte, 8'h00);
    endtask

    task automatic t_enabled_event();
        logic [7:0] v;
        reg_write(I_ENA, 8'h42);
        chk("R6 no flag irq", {7'd0, irq_line}, 8'h00);
        pulse(1'b1, 1'b0, 1'b0);
        chk("R7 enabled status", status_byte, 8'hC0);
        chk("R7 enabled irq", {7'd0, irq_line}, 8'h01);
        pulse(1'b1, 1'b0, 1'b0);
        chk("R8 repeat status", status_byte, 8'hC0);
        chk("R8 repeat irq", {7'd0, irq_line}, 8'h01);
        reg_read(I_STS, v);
        chk("R4 read value", v, 8'hC0);
        chk("R3 cleared status", status_byte, 8'h00);
        chk("R3 line low", {7'd0, irq_line}, 8'h00);
    endtask

    task automatic t_pending_enable();
        logic [7:0] v;
        reg_write(I_ENA, 8'h02);
        pulse(1'b0, 1'b1, 1'b0);
        chk("R7 alarm masked", status_byte, 8'h20);
        reg_write(I_ENA, 8'h22);
        chk("R6 pending raise status", status_byte, 8'hA0);
        chk("R6 pending raise irq", {7'd0, irq_line}, 8'h01);
        reg_write(I_ENA, 8'h42);
        chk("R6 no match status", status_byte, 8'h20);
        chk("R6 no match irq", {7'd0, irq_line}, 8'h00);
        pulse(1'b0, 1'b1, 1'b0);
        chk("R8 set flag again", status_byte, 8'h20);
        reg_read(I_STS, v);
        chk("R4 read value", v, 8'h20);
    endtask

    task automatic t_hold_bit();
        logic [7:0] v;
        reg_write(I_ENA, 8'h92);
        reg_read(I_ENA, v); chk("R9 hold drops enable", v, 8'h82);
        reg_write(I_ENA, 8'h12);
        reg_read(I_ENA, v); chk("R9 no hold keeps enable", v, 8'h12);
        pulse(1'b0, 1'b0, 1'b1);
        chk("R7 update enabled", status_byte, 8'h90);
        reg_write(I_ENA, 8'h92);
        chk("R9 hold no raise status", status_byte, 8'h10);
        chk("R9 hold no raise irq", {7'd0, irq_line}, 8'h00);
        reg_read(I_STS, v);
        reg_write(I_ENA, 8'h02);
    endtask

    task automatic t_read_only();
        logic [7:0] v;
        pulse(1'b0, 1'b1, 1'b0);
        reg_write(I_STS, 8'hFF);
        chk("R5 status write ignored", status_byte, 8'h20);
        chk("R5 irq unchanged", {7'd0, irq_line}, 8'h00);
        reg_write(I_FIX, 8'h00);
        reg_read(I_FIX, v); chk("R5 fixed byte", v, 8'h80);
        reg_write(I_CTL, 8'hA5);
        reg_read(I_CTL, v); chk("R12 ctl bit7 kept", v, 8'h25);
        reg_write(I_CTL, 8'h26);
        reg_read(I_STS, v); chk("R5 flag kept after write", v, 8'h20);
    endtask

    task automatic t_read_race();
        logic [7:0] v;
        reg_write(I_ENA, 8'h42);
        pulse(1'b0, 1'b1, 1'b0);
        wr_byte(1'b0, I_STS);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = 1'b1; evt_periodic = 1'b1;
        #1 chk("R4 race read value", bus_rdata, 8'h20);
        @(negedge clk);
        bus_re = 1'b0; bus_addr = 1'b0; evt_periodic = 1'b0;
        #1;
        chk("R11 event survives", status_byte, 8'hC0);
        chk("R11 irq raised", {7'd0, irq_line}, 8'h01);
        reg_read(I_STS, v);
        chk("R11 next read", v, 8'hC0);
        chk("R3 cleared", status_byte, 8'h00);
    endtask

    task automatic t_reset_mid();
        logic [7:0] v;
        reg_write(I_ENA, 8'h7A);
        pulse(1'b1, 1'b1, 1'b1);
        chk("R7 all sources", status_byte, 8'hF0);
        apply_reset();
        chk("R1 status after reset", status_byte, 8'h00);
        chk("R1 irq after reset", {7'd0, irq_line}, 8'h00);
        reg_read(I_ENA, v); chk("R1 ena after reset", v, 8'h02);
        reg_read(I_CTL, v); chk("R1 ctl after reset", v, 8'h26);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset_values();
        t_index_port();
        t_masked_event();
        t_enabled_event();
        t_pending_enable();
        t_hold_bit();
        t_read_only();
        t_read_race();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule